// File: doc/BRIEF.md
# Time-of-Day Register File with Read-Coherency Flag

This block holds a set of BCD time counters behind a small memory-mapped bus with chip select, read and write strobes, a 4-bit address and a 4-bit data bus. A one-cycle tick from a prescaler advances the counters. The digits run from tenths of seconds up to units of hours.

Software reads several time digits one after another. It cannot stop the counters between those reads. The block therefore keeps a sticky "changed" flag. Every tick sets it. Only a read of the control register clears it.

The software loop is short. It reads the control register, reads the time digits, and reads the control register again. If the flag was clear on that last read, the burst is consistent. If it was set, software reads the digits again and repeats the check. Each control read has already cleared the flag, so no separate reset read is needed. Time digits may be read with the strobe held for any length of time and always show the live count.

Top module: `tod_regfile`

## Requirements
- R1: After reset, every time digit is 0 and the changed flag is 0.
- R2: While chip select and read are both high, the read data is driven combinationally from the addressed register. Addresses 1 to 6 return digits in this order: tenths of seconds, seconds units, seconds tens, minutes units, minutes tens, hours units. Addresses 7 to 15 return 0. With no active read, the data bus reads 0.
- R3: A tick advances the tenths digit. A digit at or above (modulus − 1) goes to 0 and carries into the next digit. Otherwise the digit increments and the carry stops. The moduli are 10, 10, 6, 10, 6 and 10, from address 1 to address 6.
- R4: Every tick sets the changed flag. A control-register read (address 0) returns the flag at bit 3, with bits 2..0 reading 0.
- R5: The first cycle of a control-register read clears the flag. For as long as that read continues without a break, the data returned is the flag value seen in its first cycle.
- R6: Reads of any address other than 0 never change the flag. Only a tick changes it while no control read is starting.
- R7: If a tick falls in the first cycle of a control-register read, the flag ends up set.
- R8: A write takes effect only in the cycle where write rises while chip select is high. It loads the digit at addresses 1 to 6. Holding write high does not repeat the write. Writes to address 0 or to addresses 7 to 15 have no effect. A write with chip select low has no effect. Writes leave the flag unchanged.
- R9: A time-digit read with the strobe held high continuously follows the counter as it advances.
- R10: If a write and a tick fall in the same cycle, the written digit takes the written value. The other digits advance as the tick and the old digit values dictate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle counter-advance pulse from the prescaler |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high, acts on its rising edge |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data (0 when no read is active) |

## Verification
The bench steps a behavioural model beside the block and compares read data on every cycle. The tick patterns are chosen to separate the cases:
- Isolated ticks and long tick runs under a held read tell correct rollover and carry from a stuck or frozen count.
- Ticks placed before, inside and at the first cycle of a control read tell a sticky, correctly cleared flag from a lost update or an early clear.
- Repeated time-register bursts between two control reads show that the flag ignores those reads.
- Held, ungated and out-of-range writes, and writes that coincide with ticks, separate true edge-qualified loads from level-triggered or misdecoded ones.

// File: rtl/tod_regfile.sv
module tod_regfile #(
  parameter int AW       = 4,
  parameter int FLAG_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    wdata,
  output logic [3:0]    rdata
);
  localparam int ND = 6;
  localparam logic [3:0] LIM [ND] = '{4'd9, 4'd9, 4'd5, 4'd9, 4'd5, 4'd9};

  logic [3:0] dig [ND];
  logic [ND:0] cy;
  logic flag, snap, ctl_q, wr_q;

  wire ctl_rd    = cs & rd & (addr == '0);
  wire ctl_start = ctl_rd & ~ctl_q;
  wire wr_edge   = cs & wr & ~wr_q;

  assign cy[0] = tick;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    wire at_lim = dig[g] >= LIM[g];
    wire sel    = wr_edge & (addr == AW'(g + 1));
    assign cy[g+1] = cy[g] & at_lim;
    always_ff @(posedge clk) begin
      if (!rst_n)      dig[g] <= '0;
      else if (sel)    dig[g] <= wdata;
      else if (cy[g])  dig[g] <= at_lim ? 4'd0 : dig[g] + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      snap  <= 1'b0;
      ctl_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_rd;
      wr_q  <= wr;
      if (ctl_start) begin
        snap <= flag;
        flag <= tick;
      end else if (tick) begin
        flag <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (addr == '0)
        rdata[FLAG_BIT] = ctl_q ? snap : flag;
      for (int i = 0; i < ND; i++)
        if (addr == AW'(i + 1)) rdata = dig[i];
    end
  end
endmodule

module tod_regfile_chk #(
  parameter int AW       = 4,
  parameter int FLAG_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cs,
  input logic          rd,
  input logic [AW-1:0] addr,
  input logic [3:0]    rdata,
  input logic          flag,
  input logic          ctl_q
);
  wire ctl = cs && rd && (addr == '0);

  p_tick_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag);

  p_ctl_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |-> ((rdata & ~(4'b1 << FLAG_BIT)) == 4'd0));

  p_ctl_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && !ctl_q && !tick) |=> !flag);

  p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && ctl_q) |-> $stable(rdata));

  p_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(ctl && !ctl_q)) |=> $stable(flag));

  p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && !ctl_q && tick) |=> flag);

  p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == 4'd0);
endmodule

bind tod_regfile tod_regfile_chk #(.AW(AW), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .rd(rd), .addr(addr),
  .rdata(rdata), .flag(flag), .ctl_q(ctl_q)
);

// File: tb/test_tod_regfile.sv
module test_tod_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cs = 0, rd = 0, wr = 0;
  logic [3:0] addr = 0, wdata = 0;
  logic [3:0] rdata;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_regfile i_tod_regfile (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int m_d [6];
  int m_mod [6] = '{10, 10, 6, 10, 6, 10};
  bit m_flag, m_snap, m_ctlq, m_wrq;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_d[i]) m_d[i] = 0;
      m_flag = 0; m_snap = 0; m_ctlq = 0; m_wrq = 0;
    end else begin
      bit ctl, start, wedge, carry;
      ctl   = cs && rd && addr == 0;
      start = ctl && !m_ctlq;
      wedge = cs && wr && !m_wrq;
      carry = tick;
      for (int i = 0; i < 6; i++) begin
        bit roll;
        roll = m_d[i] >= m_mod[i] - 1;
        if (wedge && addr == i + 1) m_d[i] = wdata;
        else if (carry) m_d[i] = roll ? 0 : m_d[i] + 1;
        carry = carry && roll;
      end
      if (start) begin m_snap = m_flag; m_flag = tick; end
      else if (tick) m_flag = 1;
      m_ctlq = ctl;
      m_wrq  = wr;
    end
  end

  function automatic logic [3:0] expect_rd();
    if (!(cs && rd)) return 0;
    if (addr == 0) return (m_ctlq ? m_snap : m_flag) ? 4'h8 : 4'h0;
    if (addr >= 1 && addr <= 6) return 4'(m_d[addr-1]);
    return 0;
  endfunction

  task automatic step(input bit t, c, r, w, input int a, input int d, input string req);
    @(negedge clk);
    tick = t; cs = c; rd = r; wr = w; addr = 4'(a); wdata = 4'(d);
    #1;
    n_vec++;
    if (rdata !== expect_rd()) begin
      n_bad++;
      $display("FAIL %s: addr=%0d actual=%h expected=%h", req, a, rdata, expect_rd());
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) step(0, 1, 1, 0, a, 0, req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic wr_digit(input int a, input int d, input string req);
    step(0, 1, 0, 1, a, d, req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_all("R1");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 1, 0, "R2");
    // R9, R3: held read of tenths through ticks
    for (int i = 0; i < 25; i++) step(1, 1, 1, 0, 1, 0, "R9");
    step(0, 1, 1, 0, 2, 0, "R3");
    // R4, R5: control read with ticks inside the held strobe
    step(0, 1, 1, 0, 0, 0, "R4");
    step(1, 1, 1, 0, 0, 0, "R5");
    step(1, 1, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    // R6: burst of time reads leaves flag untouched
    for (int k = 0; k < 3; k++) for (int a = 1; a < 16; a++) step(0, 1, 1, 0, a, 0, "R6");
    step(0, 1, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 0, "R6");
    for (int a = 1; a < 7; a++) step(0, 1, 1, 0, a, 0, "R6");
    step(0, 1, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    // R7: tick on first cycle of control read
    step(1, 1, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    // R8: held write, ungated write, bad addresses
    step(0, 1, 0, 1, 2, 7, "R8");
    step(0, 1, 0, 1, 2, 3, "R8");
    step(0, 1, 0, 1, 2, 1, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 4, 8, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    wr_digit(0, 15, "R8");
    wr_digit(9, 6, "R8");
    read_all("R8");
    // R3: full rollover
    wr_digit(1, 9, "R3"); wr_digit(2, 9, "R3"); wr_digit(3, 5, "R3");
    wr_digit(4, 9, "R3"); wr_digit(5, 5, "R3"); wr_digit(6, 9, "R3");
    read_all("R3");
    step(1, 0, 0, 0, 0, 0, "R3");
    read_all("R3");
    // R3: out-of-range digit
    wr_digit(1, 9, "R3"); wr_digit(2, 9, "R3"); wr_digit(3, 12, "R3");
    step(1, 0, 0, 0, 0, 0, "R3");
    read_all("R3");
    // R10: write coinciding with tick
    wr_digit(1, 9, "R10"); wr_digit(2, 4, "R10");
    step(1, 1, 0, 1, 1, 3, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    read_all("R10");
    step(1, 1, 0, 1, 3, 2, "R10");
    read_all("R10");
    // long run across minutes
    for (int i = 0; i < 700; i++) step(1, 1, 1, 0, 1 + (i % 6), 0, "R3");
    step(0, 1, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    read_all("R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule